// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Carry and Zero Flags

This block is the arithmetic and logic core of a small accumulator-style microcontroller. The first operand always comes from a register. The second operand comes from either a register or an 8-bit immediate constant, and one select pin makes the choice. A 4-bit operation code picks one of ten operations. The block computes the 8-bit result and a write-enable for the destination register in the same cycle, with no register on the path. It also gives the carry and zero values that the flag register will take.

Only the two flags are stored. They update on a rising clock edge when the enable pin is high. Arithmetic with carry reads the stored carry. Some operations leave the flags alone, and two operations set the flags without writing back a result. The enable pin is a plain qualifier with no back-pressure. The caller decides in which cycle an operation is issued, and the block never stalls, so no handshake is needed.

Top module: `alu8_core`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm`. When it is 0, the second operand is `opnd_b`.
- R2: Op code 0 (copy) drives the second operand onto `result` and raises `wr_en`. Both flags keep their values.
- R3: Op codes 1 (AND), 2 (OR) and 3 (XOR) give the bitwise result and raise `wr_en`. They clear carry, and zero is 1 exactly when the result is 0.
- R4: Op codes 5 (add) and 6 (add with carry) give the sum modulo 256 and raise `wr_en`. Carry is 1 when the true sum exceeds 255. Code 6 also adds the stored carry.
- R5: Op codes 7 (subtract) and 8 (subtract with borrow) give the first operand minus the second, modulo 256, and raise `wr_en`. Carry is 1 when the true difference is negative. Code 8 also subtracts the stored carry.
- R6: Op code 4 (test) keeps `wr_en` low. It sets carry to the odd parity of the AND of the operands, and zero is 1 when that AND is 0.
- R7: Op code 9 (compare) keeps `wr_en` low. It sets carry and zero exactly as op code 7 would.
- R8: For every op code that changes the flags, zero is 1 exactly when the 8-bit computed value is 0.
- R9: The flags change only on a rising edge with `alu_en` high. With `alu_en` low, `wr_en` is 0, and `carry_next` and `zero_next` equal the stored flags.
- R10: A synchronous reset clears both stored flags.
- R11: Op codes 10 to 15 keep `wr_en` low and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the flags, active high |
| alu_en | input | 1 | Issues the operation in this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 8 | First operand, from a register |
| opnd_b | input | 8 | Register choice for the second operand |
| imm | input | 8 | Immediate choice for the second operand |
| use_imm | input | 1 | 1 selects `imm` as the second operand |
| result | output | 8 | Computed value |
| wr_en | output | 1 | Write the result to the destination register |
| carry_next | output | 1 | Carry value taken at the next enabled edge |
| zero_next | output | 1 | Zero value taken at the next enabled edge |
| carry_q | output | 1 | Stored carry flag |
| zero_q | output | 1 | Stored zero flag |

## Verification
The hardest case to reach is the one where the carry-in operations depend on the flag left by an earlier instruction, because no port sets the stored carry directly. Before each swept operation the bench therefore issues one preset instruction. Subtracting 1 from 0 leaves carry set and zero clear, and adding 0 to 0 leaves carry clear and zero set. Each operand pair and op code then runs against both flag states, and the stored flags are checked on the following edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_COPY = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_TEST = 4'd4,
    OP_ADD  = 4'd5,
    OP_ADDC = 4'd6,
    OP_SUB  = 4'd7,
    OP_SUBC = 4'd8,
    OP_CMP  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2
  } logic_fn_e;
endpackage

// File: rtl/alu8_opnd_sel.sv
module alu8_opnd_sel #(
  parameter int W = 8
) (
  input  logic         use_imm,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] imm_val,
  output logic [W-1:0] opnd
);
  assign opnd = use_imm ? imm_val : reg_val;
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int EW = W + 1;
  logic [EW-1:0] ext;
  logic [EW-1:0] cext;

  always_comb begin
    cext = {{(EW-1){1'b0}}, (use_cin & cin)};
    if (sub) ext = {1'b0, a} - {1'b0, b} - cext;
    else     ext = {1'b0, a} + {1'b0, b} + cext;
  end

  // Bit W holds the carry out on an add and the borrow on a subtract.
  assign res  = ext[W-1:0];
  assign cout = ext[W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::logic_fn_e fn,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  output logic [W-1:0]        res,
  output logic                odd_par
);
  import alu8_pkg::*;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_comb begin
        unique case (fn)
          LF_OR:   res[i] = a[i] | b[i];
          LF_XOR:  res[i] = a[i] ^ b[i];
          default: res[i] = a[i] & b[i];
        endcase
      end
    end
  endgenerate

  assign odd_par = ^res;
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic c_d,
  input  logic z_d,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (en) begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alu_en,
  input  logic [alu8_pkg::OP_W-1:0] op,
  input  logic [W-1:0]            opnd_a,
  input  logic [W-1:0]            opnd_b,
  input  logic [W-1:0]            imm,
  input  logic                    use_imm,
  output logic [W-1:0]            result,
  output logic                    wr_en,
  output logic                    carry_next,
  output logic                    zero_next,
  output logic                    carry_q,
  output logic                    zero_q
);
  import alu8_pkg::*;

  logic [W-1:0] b_sel;
  logic [W-1:0] lres;
  logic [W-1:0] ares;
  logic         lpar;
  logic         acout;
  logic_fn_e    lfn;
  logic         is_sub;
  logic         is_cin;
  logic [W-1:0] res_c;
  logic         wr_c;
  logic         c_c;
  logic         z_c;

  alu8_opnd_sel #(.W(W)) u_sel (
    .use_imm (use_imm),
    .reg_val (opnd_b),
    .imm_val (imm),
    .opnd    (b_sel)
  );

  always_comb begin
    unique case (op)
      OP_OR:   lfn = LF_OR;
      OP_XOR:  lfn = LF_XOR;
      default: lfn = LF_AND;
    endcase
    is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    is_cin = (op == OP_ADDC) || (op == OP_SUBC);
  end

  alu8_logic #(.W(W)) u_logic (
    .fn      (lfn),
    .a       (opnd_a),
    .b       (b_sel),
    .res     (lres),
    .odd_par (lpar)
  );

  alu8_addsub #(.W(W)) u_arith (
    .a       (opnd_a),
    .b       (b_sel),
    .sub     (is_sub),
    .use_cin (is_cin),
    .cin     (carry_q),
    .res     (ares),
    .cout    (acout)
  );

  always_comb begin
    res_c = '0;
    wr_c  = 1'b0;
    c_c   = carry_q;
    z_c   = zero_q;
    unique case (op)
      OP_COPY: begin
        res_c = b_sel;
        wr_c  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_c = lres;
        wr_c  = 1'b1;
        c_c   = 1'b0;
        z_c   = (lres == '0);
      end
      OP_TEST: begin
        res_c = lres;
        c_c   = lpar;
        z_c   = (lres == '0);
      end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res_c = ares;
        wr_c  = (op != OP_CMP);
        c_c   = acout;
        z_c   = (ares == '0);
      end
      default: ;
    endcase
  end

  assign result     = res_c;
  assign wr_en      = alu_en & wr_c;
  assign carry_next = alu_en ? c_c : carry_q;
  assign zero_next  = alu_en ? z_c : zero_q;

  alu8_flags u_flags (
    .clk (clk),
    .rst (rst),
    .en  (alu_en),
    .c_d (carry_next),
    .z_d (zero_next),
    .c_q (carry_q),
    .z_q (zero_q)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      alu_en,
  input logic [alu8_pkg::OP_W-1:0] op,
  input logic [W-1:0]              result,
  input logic                      wr_en,
  input logic                      carry_next,
  input logic                      zero_next,
  input logic                      carry_q,
  input logic                      zero_q
);
  import alu8_pkg::*;

  assert_idle_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !alu_en |=> (carry_q == $past(carry_q)) && (zero_q == $past(zero_q)));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !alu_en |-> !wr_en);

  assert_flags_take_next_R9: assert property (@(posedge clk) disable iff (rst)
    alu_en |=> (carry_q == $past(carry_next)) && (zero_q == $past(zero_next)));

  assert_copy_keeps_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_en && op == OP_COPY) |=> (carry_q == $past(carry_q)) && (zero_q == $past(zero_q)));

  assert_logic_clears_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (alu_en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |-> !carry_next);

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (alu_en && op == OP_TEST) |-> !wr_en);

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (alu_en && op == OP_CMP) |-> !wr_en);

  assert_zero_tracks_result_R8: assert property (@(posedge clk) disable iff (rst)
    (alu_en && op != OP_COPY && op <= OP_CMP) |-> (zero_next == (result == '0)));

  assert_unused_inert_R11: assert property (@(posedge clk) disable iff (rst)
    (alu_en && op > OP_CMP) |=> !$past(wr_en) && (carry_q == $past(carry_q)) && (zero_q == $past(zero_q)));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!carry_q && !zero_q));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alu_en     (alu_en),
  .op         (op),
  .result     (result),
  .wr_en      (wr_en),
  .carry_next (carry_next),
  .zero_next  (zero_next),
  .carry_q    (carry_q),
  .zero_q     (zero_q)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alu_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opnd_a = 8'd0;
  logic [7:0] opnd_b = 8'd0;
  logic [7:0] imm = 8'd0;
  logic       use_imm = 1'b0;
  logic [7:0] result;
  logic       wr_en;
  logic       carry_next;
  logic       zero_next;
  logic       carry_q;
  logic       zero_q;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .alu_en(alu_en), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .use_imm(use_imm),
    .result(result), .wr_en(wr_en), .carry_next(carry_next),
    .zero_next(zero_next), .carry_q(carry_q), .zero_q(zero_q)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input int o);
    case (o)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R6";
      5, 6: return "R4";
      7, 8: return "R5";
      9: return "R7";
      default: return "R11";
    endcase
  endfunction

  // Reference model: returns {wr, c, z, res[7:0]}.
  function automatic logic [10:0] model(input int o, input int a, input int b, input int ci, input int zi);
    int v;
    int r;
    logic wr;
    logic c;
    logic z;
    wr = 1'b0; c = ci[0]; z = zi[0]; r = 0;
    case (o)
      0: begin r = b; wr = 1'b1; end
      1, 2, 3, 4: begin
        r = (o == 2) ? (a | b) : (o == 3) ? (a ^ b) : (a & b);
        wr = (o != 4);
        c = 1'b0;
        if (o == 4) for (int k = 0; k < 8; k++) c = c ^ r[k];
        z = (r == 0);
      end
      5, 6: begin
        v = a + b + ((o == 6) ? ci : 0);
        r = v & 255; wr = 1'b1; c = (v > 255); z = (r == 0);
      end
      7, 8, 9: begin
        v = a - b - ((o == 8) ? ci : 0);
        r = v & 255; wr = (o != 9); c = (v < 0); z = (r == 0);
      end
      default: ;
    endcase
    return {wr, c, z, r[7:0]};
  endfunction

  task automatic issue(input int o, input int a, input int b, input bit imm_sel);
    @(negedge clk);
    alu_en = 1'b1;
    op = o[3:0];
    opnd_a = a[7:0];
    use_imm = imm_sel;
    if (imm_sel) begin imm = b[7:0]; opnd_b = ~b[7:0]; end
    else begin opnd_b = b[7:0]; imm = ~b[7:0]; end
  endtask

  // Leave carry = ci and zero = !ci after the next edge.
  task automatic preset(input int ci);
    if (ci != 0) issue(7, 0, 1, 1'b0);
    else issue(5, 0, 0, 1'b0);
  endtask

  task automatic run_one(input int o, input int a, input int b, input int ci, input bit isel);
    logic [10:0] e;
    string t;
    preset(ci);
    issue(o, a, b, isel);
    e = model(o, a, b, ci, (ci == 0) ? 1 : 0);
    t = op_tag(o);
    #1;
    chk(t, "wr_en", wr_en, e[10]);
    if (e[10]) chk(isel ? "R1" : t, "result", result, e[7:0]);
    chk(t, "carry_next", carry_next, e[9]);
    chk((o >= 1 && o <= 9) ? "R8" : t, "zero_next", zero_next, e[8]);
    @(posedge clk); #1;
    chk(t, "carry_q", carry_q, e[9]);
    chk(t, "zero_q", zero_q, e[8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "carry_q after reset", carry_q, 0);
    chk("R10", "zero_q after reset", zero_q, 0);
    @(negedge clk); rst = 1'b0;

    // Directed boundaries
    run_one(5, 255, 1, 0, 1'b0);   // R4 wrap to zero
    run_one(6, 255, 0, 1, 1'b1);   // R4 carry-in wraps
    run_one(8, 0, 0, 1, 1'b0);     // R5 borrow-in underflow
    run_one(4, 8'hff, 8'h07, 0, 1'b1); // R6 odd parity
    run_one(9, 5, 5, 1, 1'b0);     // R7 equal
    run_one(12, 1, 2, 1, 1'b0);    // R11 unused code

    // R9: idle cycle with an op on the pins
    preset(1);
    @(negedge clk);
    alu_en = 1'b0; op = 4'd5; opnd_a = 8'd255; opnd_b = 8'd1; use_imm = 1'b0;
    #1;
    chk("R9", "wr_en idle", wr_en, 0);
    chk("R9", "carry_next idle", carry_next, 1);
    chk("R9", "zero_next idle", zero_next, 0);
    @(posedge clk); #1;
    chk("R9", "carry_q idle", carry_q, 1);
    chk("R9", "zero_q idle", zero_q, 0);

    // R10: reset clears set flags
    preset(1);
    @(negedge clk); alu_en = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk("R10", "carry_q reset", carry_q, 0);
    chk("R10", "zero_q reset", zero_q, 0);
    @(negedge clk); rst = 1'b0;

    // Sweep: operands in steps of 15, every op code, both flag states, both operand sources
    for (int o = 0; o < 16; o++)
      for (int ia = 0; ia < 18; ia++)
        for (int ib = 0; ib < 18; ib++)
          for (int ci = 0; ci < 2; ci++)
            run_one(o, ia * 15, ib * 15, ci, ((ia + ib + ci) % 2) == 1);

    @(negedge clk); alu_en = 1'b0;
    finish_run();
  end
endmodule